// File: doc/BRIEF.md
# Branch Resolution Unit

This block resolves every control-flow instruction of a 16-bit instruction stream in one registered step. Given an instruction word, its even address, the most recent short-term result (S0), the constant-continuation flag, the four condition flags and a register operand for indirect jumps, it produces the next program counter, the 64-bit value the instruction writes into the short-term FIFO, and a taken indication. Branch offsets are encoded so that an odd value stands for a negative offset: the value or its bitwise inverse, whichever is even, is added to the instruction address. When the continuation flag is set, S0 supplies the offset's upper bits.

A return-address stack, eight entries by default, runs beside the resolver. Subroutine calls, direct or indirect, push the sequential address. Returns pop it and report it as a prediction that a fetch unit can compare against the resolved target. Plain jumps leave the stack alone. The software-interrupt and page-map opcodes are not executed here: they raise a trap request for the privileged machinery.

All results are registered. An instruction presented with `in_valid` high is resolved at the next rising clock edge, and the stack is updated at that same edge.

Top module: `branch_resolve_unit`

## Requirements
- R1: While `rst_n` is low, every output is zero and the return stack is emptied.
- R2: The outputs for an instruction presented with `in_valid` high appear after the next rising edge, with `out_valid` high. After a cycle with `in_valid` low, every output is zero and the return stack keeps its contents.
- R3: A word that is not a control-flow or trap opcode gives `ctl_flow`=0, `taken`=0, `result`=0 and `next_pc`=`pc_in`+2.
- R4: Bits 15..11 equal to 11100 (jump) or 11101 (call) give `taken`=1 and `result`=`pc_in`+2. `next_pc` is `pc_in`+E(off), where off is bits 10..0 zero-extended and ORed with (S0<<11) when `cont_flag`=1, and E(x) is x if x is even and ~x otherwise.
- R5: Bits 15..11 equal to 11111 with bits 10..8 not equal to 111 form a conditional branch. Its offset is bits 6..0 zero-extended, ORed with (S0<<7) when `cont_flag`=1, and passed through E().
- R6: The condition code is bits 10..8, tested against `nzcv`={N,Z,C,V}: 000 Z, 001 C, 010 N, 011 V, 100 C&!Z, 101 N==V, 110 (N==V)&!Z.
- R7: Bit 7 set inverts the tested condition.
- R8: A conditional branch whose test passes gives `taken`=1, `result` all ones and the branch target. One that fails gives `taken`=0, `result`=0 and `next_pc`=`pc_in`+2. Both set `ctl_flow`=1.
- R9: Bits 15..7 equal to 111111110 with bits 6..5 equal to 00 (jump), 01 (call) or 10 (return) give `taken`=1, `next_pc`=`ind_target` and `result`=`pc_in`+2.
- R10: Direct and indirect calls push `pc_in`+2. A return pops the newest entry and reports it on `pred_addr` with `pred_valid`=1 in the same output cycle.
- R11: Direct and indirect jumps leave the return stack unchanged.
- R12: The stack holds `RAS_DEPTH` (8) entries. A push onto a full stack discards the oldest entry.
- R13: A return on an empty stack gives `pred_valid`=0 and `pred_addr`=0. All other words also give `pred_valid`=0.
- R14: Software interrupt (bits 15..5 = 11111111011) and page map (bits 15..5 = 11111111100) give `trap_req`=1, `ctl_flow`=1, `taken`=0, `next_pc`=`pc_in`+2 and `result`=`pc_in`+2, and leave the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction presented this cycle |
| instr | input | 16 | Instruction word |
| pc_in | input | 64 | Address of the instruction (even) |
| s0_val | input | 64 | Newest short-term register value |
| cont_flag | input | 1 | Previous instruction was a constant continuation |
| nzcv | input | 4 | Condition flags {N,Z,C,V} |
| ind_target | input | 64 | Register operand for indirect jumps |
| out_valid | output | 1 | Registered result is valid |
| ctl_flow | output | 1 | Instruction was a control-flow or trap opcode |
| taken | output | 1 | Control transfers to a non-sequential target |
| next_pc | output | 64 | Resolved next program counter |
| result | output | 64 | Value written into the short-term FIFO |
| trap_req | output | 1 | Privileged trap requested |
| pred_valid | output | 1 | Return prediction available |
| pred_addr | output | 64 | Predicted return address |

## Verification
Every result of this block is due exactly one rising edge after its instruction is driven, and the stack changes at that same edge. A return therefore shows the address pushed by a call issued any number of cycles earlier, as soon as the return's own outputs appear. The bench drives inputs on the falling edge, lets one rising edge pass, and compares every output on the following falling edge against a queue-based model that was advanced for that instruction. Stack effects that cannot be seen at once, such as an idle cycle, a plain jump or a trap, are observed through the prediction of a later return.

// File: rtl/bru_pkg.sv
package bru_pkg;

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_DJUMP = 3'd1,
        K_DCALL = 3'd2,
        K_BCOND = 3'd3,
        K_IJUMP = 3'd4,
        K_ICALL = 3'd5,
        K_IRET  = 3'd6,
        K_TRAP  = 3'd7
    } bru_kind_e;

    localparam int unsigned LONG_SHIFT  = 11;
    localparam int unsigned SHORT_SHIFT = 7;

endpackage

// File: rtl/bru_decode.sv
module bru_decode
    import bru_pkg::*;
(
    input  logic [15:5] opc,
    output bru_kind_e   kind,
    output logic [2:0]  cond_code,
    output logic        cond_inv
);

    always_comb begin
        kind = K_NONE;
        if (opc[15:11] == 5'b11100) begin
            kind = K_DJUMP;
        end else if (opc[15:11] == 5'b11101) begin
            kind = K_DCALL;
        end else if (opc[15:11] == 5'b11111 && opc[10:8] != 3'b111) begin
            kind = K_BCOND;
        end else if (opc[15:7] == 9'b111111110) begin
            case (opc[6:5])
                2'b00:   kind = K_IJUMP;
                2'b01:   kind = K_ICALL;
                2'b10:   kind = K_IRET;
                default: kind = K_TRAP;
            endcase
        end else if (opc[15:5] == 11'b11111111100) begin
            kind = K_TRAP;
        end
    end

    assign cond_code = opc[10:8];
    assign cond_inv  = opc[7];

endmodule

// File: rtl/bru_cond.sv
module bru_cond (
    input  logic [2:0] code,
    input  logic       inv,
    input  logic [3:0] nzcv,
    output logic       pass
);

    logic flag_n, flag_z, flag_c, flag_v;
    logic raw;

    assign flag_n = nzcv[3];
    assign flag_z = nzcv[2];
    assign flag_c = nzcv[1];
    assign flag_v = nzcv[0];

    always_comb begin
        case (code)
            3'd0:    raw = flag_z;
            3'd1:    raw = flag_c;
            3'd2:    raw = flag_n;
            3'd3:    raw = flag_v;
            3'd4:    raw = flag_c & ~flag_z;
            3'd5:    raw = (flag_n == flag_v);
            3'd6:    raw = (flag_n == flag_v) & ~flag_z;
            default: raw = 1'b0;
        endcase
    end

    assign pass = (code != 3'd7) && (raw ^ inv);

endmodule

// File: rtl/bru_target.sv
module bru_target
    import bru_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] s0,
    input  logic            cont,
    input  logic            short_form,
    input  logic [10:0]     off_field,
    output logic [XLEN-1:0] target
);

    logic [XLEN-1:0] low_part;
    logic [XLEN-1:0] high_part;
    logic [XLEN-1:0] raw_off;
    logic [XLEN-1:0] even_off;

    always_comb begin
        if (short_form) begin
            low_part  = XLEN'(off_field[SHORT_SHIFT-1:0]);
            high_part = cont ? (s0 << SHORT_SHIFT) : '0;
        end else begin
            low_part  = XLEN'(off_field);
            high_part = cont ? (s0 << LONG_SHIFT) : '0;
        end
        raw_off  = low_part | high_part;
        even_off = raw_off[0] ? ~raw_off : raw_off;
        target   = pc + even_off;
    end

endmodule

// File: rtl/ras_stack.sv
module ras_stack #(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned DEPTH = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic                           pop,
    input  logic [XLEN-1:0]                push_data,
    output logic [XLEN-1:0]                top_data,
    output logic                           nonempty,
    output logic [$clog2(DEPTH+1)-1:0]     level
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][XLEN-1:0] mem;
        logic [PTR_W-1:0]           wp;
        logic [CNT_W-1:0]           cnt;
    } ras_state_t;

    ras_state_t st_d, st_q;
    logic [PTR_W-1:0] rd_idx;

    assign rd_idx   = (st_q.wp == '0) ? PTR_W'(DEPTH - 1) : st_q.wp - 1'b1;
    assign top_data = st_q.mem[rd_idx];
    assign nonempty = (st_q.cnt != '0);
    assign level    = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wp] = push_data;
            st_d.wp = (st_q.wp == PTR_W'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
            if (st_q.cnt != CNT_W'(DEPTH)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (pop && nonempty) begin
            st_d.wp  = rd_idx;
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R12: occupancy never exceeds the configured depth
    assert_level_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    // R12: pushing onto a full stack keeps it full
    assert_full_push_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (push && st_q.cnt == CNT_W'(DEPTH)) |=> (st_q.cnt == CNT_W'(DEPTH)));

    // R10: a push below capacity grows the stack by one
    assert_push_grow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && st_q.cnt != CNT_W'(DEPTH)) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R13: popping an empty stack leaves it empty
    assert_empty_pop_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && st_q.cnt == '0) |=> (st_q.cnt == '0));

endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
    import bru_pkg::*;
#(
    parameter int unsigned XLEN      = 64,
    parameter int unsigned RAS_DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [15:0]     instr,
    input  logic [XLEN-1:0] pc_in,
    input  logic [XLEN-1:0] s0_val,
    input  logic            cont_flag,
    input  logic [3:0]      nzcv,
    input  logic [XLEN-1:0] ind_target,
    output logic            out_valid,
    output logic            ctl_flow,
    output logic            taken,
    output logic [XLEN-1:0] next_pc,
    output logic [XLEN-1:0] result,
    output logic            trap_req,
    output logic            pred_valid,
    output logic [XLEN-1:0] pred_addr
);

    localparam int unsigned CNT_W = $clog2(RAS_DEPTH + 1);

    typedef struct packed {
        logic            valid;
        logic            ctl;
        logic            taken;
        logic [XLEN-1:0] next_pc;
        logic [XLEN-1:0] result;
        logic            trap;
        logic            pred_valid;
        logic [XLEN-1:0] pred_addr;
    } bru_out_t;

    bru_out_t out_d, out_q;

    bru_kind_e       dec_kind;
    logic [2:0]      cond_code;
    logic            cond_inv;
    logic            cond_pass;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] rel_target;
    logic            ras_push, ras_pop;
    logic [XLEN-1:0] ras_top;
    logic            ras_nonempty;
    logic [CNT_W-1:0] ras_level;

    assign seq_pc = pc_in + XLEN'(2);

    bru_decode u_dec (
        .opc       (instr[15:5]),
        .kind      (dec_kind),
        .cond_code (cond_code),
        .cond_inv  (cond_inv)
    );

    bru_cond u_cond (
        .code (cond_code),
        .inv  (cond_inv),
        .nzcv (nzcv),
        .pass (cond_pass)
    );

    bru_target #(.XLEN(XLEN)) u_tgt (
        .pc         (pc_in),
        .s0         (s0_val),
        .cont       (cont_flag),
        .short_form (dec_kind == K_BCOND),
        .off_field  (instr[10:0]),
        .target     (rel_target)
    );

    assign ras_push = in_valid && (dec_kind == K_DCALL || dec_kind == K_ICALL);
    assign ras_pop  = in_valid && (dec_kind == K_IRET);

    ras_stack #(.XLEN(XLEN), .DEPTH(RAS_DEPTH)) u_ras (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ras_push),
        .pop       (ras_pop),
        .push_data (seq_pc),
        .top_data  (ras_top),
        .nonempty  (ras_nonempty),
        .level     (ras_level)
    );

    always_comb begin
        out_d = '0;
        if (in_valid) begin
            out_d.valid   = 1'b1;
            out_d.next_pc = seq_pc;
            case (dec_kind)
                K_DJUMP, K_DCALL: begin
                    out_d.ctl     = 1'b1;
                    out_d.taken   = 1'b1;
                    out_d.next_pc = rel_target;
                    out_d.result  = seq_pc;
                end
                K_BCOND: begin
                    out_d.ctl = 1'b1;
                    if (cond_pass) begin
                        out_d.taken   = 1'b1;
                        out_d.next_pc = rel_target;
                        out_d.result  = '1;
                    end
                end
                K_IJUMP, K_ICALL: begin
                    out_d.ctl     = 1'b1;
                    out_d.taken   = 1'b1;
                    out_d.next_pc = ind_target;
                    out_d.result  = seq_pc;
                end
                K_IRET: begin
                    out_d.ctl        = 1'b1;
                    out_d.taken      = 1'b1;
                    out_d.next_pc    = ind_target;
                    out_d.result     = seq_pc;
                    out_d.pred_valid = ras_nonempty;
                    out_d.pred_addr  = ras_nonempty ? ras_top : '0;
                end
                K_TRAP: begin
                    out_d.ctl    = 1'b1;
                    out_d.trap   = 1'b1;
                    out_d.result = seq_pc;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid  = out_q.valid;
    assign ctl_flow   = out_q.ctl;
    assign taken      = out_q.taken;
    assign next_pc    = out_q.next_pc;
    assign result     = out_q.result;
    assign trap_req   = out_q.trap;
    assign pred_valid = out_q.pred_valid;
    assign pred_addr  = out_q.pred_addr;

    // R2: an idle cycle produces an idle output cycle
    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8: a taken conditional branch writes all ones
    assert_taken_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid && dec_kind == K_BCOND) && taken) |-> (result == '1));

    // R3: any non-taken valid output falls through to the sequential address
    assert_fallthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !taken) |-> (next_pc == $past(pc_in) + XLEN'(2)));

    // R14: a trap request never accompanies a taken transfer or a prediction
    assert_trap_quiet_R14: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap_req, taken}) && !(trap_req && pred_valid));

    // R14: a trap leaves the return stack depth unchanged
    assert_trap_stack_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_kind == K_TRAP) |=> $stable(ras_level));

endmodule

// File: tb/tb_branch_resolve_unit.sv
module tb_branch_resolve_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] instr;
    logic [63:0] pc_in, s0_val, ind_target;
    logic        cont_flag;
    logic [3:0]  nzcv;
    logic        out_valid, ctl_flow, taken, trap_req, pred_valid;
    logic [63:0] next_pc, result, pred_addr;

    always #10 clk = ~clk;

    branch_resolve_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .pc_in(pc_in), .s0_val(s0_val), .cont_flag(cont_flag), .nzcv(nzcv),
        .ind_target(ind_target), .out_valid(out_valid), .ctl_flow(ctl_flow),
        .taken(taken), .next_pc(next_pc), .result(result), .trap_req(trap_req),
        .pred_valid(pred_valid), .pred_addr(pred_addr)
    );

    int checks = 0;
    int fails  = 0;
    logic [63:0] ras_model[$];

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] evn(input logic [63:0] x);
        return x[0] ? ~x : x;
    endfunction

    function automatic bit cond_ok(input logic [2:0] c, input logic [3:0] f);
        bit n = f[3], z = f[2], cy = f[1], v = f[0];
        case (c)
            3'd0: return z;
            3'd1: return cy;
            3'd2: return n;
            3'd3: return v;
            3'd4: return cy && !z;
            3'd5: return n == v;
            3'd6: return (n == v) && !z;
            default: return 0;
        endcase
    endfunction

    task automatic step(input string tag, input logic [15:0] i, input logic [63:0] pc,
                        input logic [63:0] s0, input bit q, input logic [3:0] f,
                        input logic [63:0] tgt, input bit v);
        bit          e_valid = 0, e_ctl = 0, e_taken = 0, e_trap = 0, e_pv = 0;
        logic [63:0] e_next = 0, e_res = 0, e_pa = 0, raw;
        in_valid = v; instr = i; pc_in = pc; s0_val = s0; cont_flag = q;
        nzcv = f; ind_target = tgt;
        if (v) begin
            e_valid = 1; e_next = pc + 2;
            if (i[15:12] == 4'b1110) begin
                raw = q ? ((s0 << 11) | 64'(i[10:0])) : 64'(i[10:0]);
                e_ctl = 1; e_taken = 1; e_next = pc + evn(raw); e_res = pc + 2;
                if (i[11]) begin
                    if (ras_model.size() == 8) void'(ras_model.pop_front());
                    ras_model.push_back(pc + 2);
                end
            end else if (i[15:11] == 5'b11111 && i[10:8] != 3'b111) begin
                e_ctl = 1;
                if (cond_ok(i[10:8], f) ^ i[7]) begin
                    raw = q ? ((s0 << 7) | 64'(i[6:0])) : 64'(i[6:0]);
                    e_taken = 1; e_next = pc + evn(raw); e_res = '1;
                end
            end else if (i[15:7] == 9'b111111110 && i[6:5] != 2'b11) begin
                e_ctl = 1; e_taken = 1; e_next = tgt; e_res = pc + 2;
                if (i[6:5] == 2'b01) begin
                    if (ras_model.size() == 8) void'(ras_model.pop_front());
                    ras_model.push_back(pc + 2);
                end else if (i[6:5] == 2'b10 && ras_model.size() > 0) begin
                    e_pv = 1; e_pa = ras_model.pop_back();
                end
            end else if (i[15:5] == 11'b11111111011 || i[15:5] == 11'b11111111100) begin
                e_ctl = 1; e_trap = 1; e_res = pc + 2;
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(tag, "out_valid", 64'(out_valid), 64'(e_valid));
        chk(tag, "ctl_flow", 64'(ctl_flow), 64'(e_ctl));
        chk(tag, "taken", 64'(taken), 64'(e_taken));
        chk(tag, "next_pc", next_pc, e_next);
        chk(tag, "result", result, e_res);
        chk(tag, "trap_req", 64'(trap_req), 64'(e_trap));
        chk(tag, "pred_valid", 64'(pred_valid), 64'(e_pv));
        chk(tag, "pred_addr", pred_addr, e_pa);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 0; in_valid = 0; instr = 0; pc_in = 0; s0_val = 0;
        cont_flag = 0; nzcv = 0; ind_target = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "out_valid", 64'(out_valid), 0);
        chk("R1", "taken", 64'(taken), 0);
        chk("R1", "next_pc", next_pc, 0);
        chk("R1", "pred_valid", 64'(pred_valid), 0);
        rst_n = 1;
        @(negedge clk);

        // R3: ordinary words
        step("R3", 16'h1234, 64'h1000, 64'h5, 0, 4'h0, 64'h0, 1);
        step("R3", 16'hC0FF, 64'h2000, 64'h5, 1, 4'hF, 64'h0, 1);
        // R13: return on empty stack
        step("R13", 16'hFF40, 64'h3000, 0, 0, 0, 64'h4444, 1);
        // R2: idle call must not push, next return still empty
        step("R2", 16'hE800, 64'h3100, 0, 0, 0, 0, 0);
        step("R2", 16'hFF40, 64'h3200, 0, 0, 0, 64'h10, 1);
        // R4: direct jump forward, backward (odd offset), with continuation
        step("R4", 16'hE010, 64'h1000, 0, 0, 0, 0, 1);
        step("R4", 16'hE011, 64'h1000, 0, 0, 0, 0, 1);
        step("R4", 16'hE002, 64'h1000, 64'h5, 1, 0, 0, 1);
        step("R4", 16'hE7FF, 64'h8000_0000, 64'h3, 1, 0, 0, 1);
        // R10 R11: call, jumps, then return predicts the call's address
        step("R10", 16'hE820, 64'h5000, 0, 0, 0, 0, 1);
        step("R11", 16'hE004, 64'h6000, 0, 0, 0, 0, 1);
        step("R11", 16'hFF00, 64'h6100, 0, 0, 0, 64'h7000, 1);
        // R14: traps leave the stack alone
        step("R14", 16'hFF65, 64'h6200, 0, 0, 0, 0, 1);
        step("R14", 16'hFF83, 64'h6300, 0, 0, 0, 0, 1);
        step("R10", 16'hFF40, 64'h6400, 0, 0, 0, 64'h5002, 1);
        // R9: indirect call then return
        step("R9", 16'hFF20, 64'h9000, 0, 0, 0, 64'hABCD_0000, 1);
        step("R9", 16'hFF40, 64'hABCD_0010, 0, 0, 0, 64'h9002, 1);
        // R5 R6 R7 R8: every condition code, plain and inverted, several flag sets
        for (int fl = 0; fl < 16; fl++) begin
            for (int c = 0; c < 7; c++) begin
                step("R6", {5'b11111, 3'(c), 1'b0, 7'h08}, 64'h4000, 0, 0, 4'(fl), 0, 1);
                step("R7", {5'b11111, 3'(c), 1'b1, 7'h09}, 64'h4000, 0, 0, 4'(fl), 0, 1);
            end
        end
        step("R5", 16'hF87F, 64'h4000, 64'h2, 1, 4'h4, 0, 1);
        step("R5", 16'hF830, 64'h4000, 64'hFFFF_FFFF_FFFF_FFFF, 1, 4'h4, 0, 1);
        step("R8", 16'hF810, 64'h4000, 0, 0, 4'h0, 0, 1);
        // R12: ten calls overflow, nine returns
        for (int k = 0; k < 10; k++)
            step("R12", 16'hE802, 64'h100 * (k + 1), 0, 0, 0, 0, 1);
        for (int k = 0; k < 9; k++)
            step("R12", 16'hFF40, 64'h20000, 0, 0, 0, 64'h1, 1);
        // mixed stream
        for (int n = 0; n < 600; n++) begin
            logic [15:0] w;
            case ($urandom % 6)
                0: w = {1'b0, 15'($urandom)};
                1: w = {4'b1110, 12'($urandom)};
                2: w = {5'b11111, 3'($urandom % 7), 8'($urandom)};
                3: w = {9'b111111110, 7'($urandom)};
                4: w = {11'b11111111100, 5'($urandom)};
                default: w = 16'($urandom);
            endcase
            step("MIX", w, {$urandom, $urandom} & ~64'h1, {$urandom, $urandom},
                 1'($urandom), 4'($urandom), {$urandom, $urandom}, ($urandom % 8) != 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule